// File: doc/BRIEF.md
# Regulator Control Register Slave on a Two-Wire Bus

This block is the digital control port of a step-down voltage regulator. It listens on an I2C bus at a fixed device address and holds three 8-bit registers: a control register and two output-voltage setpoints. The control register combines two writable control bits with three live hardware status flags. The bus lines reach the block as raw pad levels. It samples them against its own system clock, so the system clock must run well above the bus rate.

A host writes one register per transaction: address byte, pointer byte, data byte. A read is a pointer-only write, then a repeated START, the read address, and one byte from the slave. The chip-enable level controls the whole register file. While it is low, every register reads as zero and ignores writes. On its rising edge the registers load their power-up values.

Top module: `vreg_ctl_i2c`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x5B (bus bytes 0xB6 for write and 0xB7 for read). Any other address gets no acknowledge, and the rest of that transaction has no effect.
- R2: Only bits [2:0] of the pointer byte select a register, so pointer 0x0B reaches register 3.
- R3: In a write, the slave acknowledges the address, pointer and data bytes. The data byte is stored in the addressed register, and the setpoint outputs follow it (register 2 drives `vset_lo`, register 3 drives `vset_hi`).
- R4: A pointer write, then a repeated START, then address 0xB7 returns the addressed register MSB first in the next eight clocks.
- R5: Register 1 reads as {0, therm_trip, undervolt, power_ok, 0, 0, slow_start, conv_on} from bit 7 down to bit 0. Only bits 1:0 are writable. The status bits show the live inputs and ignore writes.
- R6: On a rising edge of `chip_en`, register 1 becomes 0x01, register 2 becomes 0x1E and register 3 becomes 0x0A.
- R7: While `chip_en` is low, and after reset, every register output is zero, writes have no effect and every read returns 0x00.
- R8: A data byte sent to pointer 0 or 4-7 is not acknowledged and changes no register. Reads at those pointers return 0x00.
- R9: A START or STOP at any bit position aborts the byte in progress and releases SDA. A new START begins a fresh address byte.
- R10: After the last bit of a read byte, the slave releases SDA and keeps it released until the next START.
- R11: If the enable rising edge and a data-byte commit fall in the same clock cycle, the power-up values win.
- R12: The SDA pull-down changes only while the sampled SCL is low, except for a release caused by START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| therm_trip | input | 1 | Over-temperature status |
| undervolt | input | 1 | Supply undervoltage status |
| power_ok | input | 1 | Output-in-regulation status |
| chip_en | input | 1 | Chip enable level, synchronous to clk |
| sda_pull | output | 1 | Open-drain SDA pull-down enable |
| conv_on | output | 1 | Converter run bit (register 1 bit 0) |
| slow_start | output | 1 | Extended soft-start bit (register 1 bit 1) |
| vset_lo | output | 8 | Setpoint register 2 |
| vset_hi | output | 8 | Setpoint register 3 |

## Verification
Two events can land in the same clock cycle: the enable rising edge that reloads power-up values, and the commit of a data byte at the falling edge of its eighth SCL clock. The bench delays the enable edge by a counted number of clocks after that falling edge, so that the edge lands either exactly on the commit cycle or one cycle earlier. In the first case the setpoint must show the power-up value. In the second it must show the written byte.

// File: rtl/vreg_ctl_pkg.sv
// Shared constants and state types for the regulator control register slave.
// Assumes an 8-bit data path and a register file with the control register
// at index 1 and the setpoints at consecutive indices from 2.
package vreg_ctl_pkg;
    localparam int BYTE_W   = 8;
    localparam int CTL_IDX  = 1;
    localparam int SET_BASE = 2;
    localparam int N_STAT   = 3;
    localparam logic [1:0] CTL_RESET_BITS = 2'b01;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_PTR,
        LK_WDATA,
        LK_ACK,
        LK_TX
    } link_st_e;

    typedef enum logic [1:0] {
        NX_PTR,
        NX_WDATA,
        NX_TX,
        NX_IDLE
    } after_ack_e;
endpackage

// File: rtl/vreg_ctl_sync.sv
// Synchronises raw bus lines and status inputs into the clk domain and
// derives SCL edges and START/STOP conditions from the synchronised levels.
// Assumes clk is fast enough to see every SCL phase for several cycles.
module vreg_ctl_sync
    import vreg_ctl_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int NS     = N_STAT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic [NS-1:0] stat_in,
    output logic          scl_lvl,
    output logic          sda_lvl,
    output logic [NS-1:0] stat_q,
    output logic          scl_rise,
    output logic          scl_fall,
    output logic          start_det,
    output logic          stop_det
);
    localparam int W = 2 + NS;
    localparam logic [W-1:0] RST_VAL = {2'b11, {NS{1'b0}}};

    logic [W-1:0] chain [STAGES];
    logic         scl_d;
    logic         sda_d;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop of the synchroniser chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= {scl_in, sda_in, stat_in};
                end
            end else begin : g_next
                // Further synchroniser flops.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign scl_lvl = chain[STAGES-1][W-1];
    assign sda_lvl = chain[STAGES-1][W-2];
    assign stat_q  = chain[STAGES-1][NS-1:0];

    // One-cycle history of the synchronised bus for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_lvl;
            sda_d <= sda_lvl;
        end
    end

    assign scl_rise  = scl_lvl & ~scl_d;
    assign scl_fall  = ~scl_lvl & scl_d;
    assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/vreg_ctl_link.sv
// Byte-level bus state machine: shifts in the address, pointer and data
// bytes on SCL rising edges, drives acknowledge and read data after SCL
// falling edges, and issues one write strobe per accepted data byte.
// Assumes START/STOP and edge pulses come from vreg_ctl_sync.
module vreg_ctl_link
    import vreg_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h5B,
    parameter int         PTR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_lvl,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              ptr_ok,
    output logic              sda_pull,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data,
    output logic [PTR_W-1:0]  ptr
);
    link_st_e         state;
    after_ack_e       nxt;
    logic [3:0]       cnt;
    logic [BYTE_W-1:0] sh;
    logic [PTR_W-1:0] ptr_q;
    logic             pull_q;

    // Bus protocol sequencing, bit counting and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= LK_IDLE;
            nxt    <= NX_IDLE;
            cnt    <= '0;
            sh     <= '0;
            ptr_q  <= '0;
            pull_q <= 1'b0;
        end else if (start_det) begin
            state  <= LK_ADDR;
            cnt    <= '0;
            pull_q <= 1'b0;
        end else if (stop_det) begin
            state  <= LK_IDLE;
            cnt    <= '0;
            pull_q <= 1'b0;
        end else begin
            case (state)
                LK_ADDR, LK_PTR, LK_WDATA: begin
                    if (scl_rise && cnt != 4'd8) begin
                        sh  <= {sh[BYTE_W-2:0], sda_lvl};
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall && cnt == 4'd8) begin
                        cnt <= '0;
                        case (state)
                            LK_ADDR: begin
                                if (sh[7:1] == DEV_ADDR) begin
                                    pull_q <= 1'b1;
                                    state  <= LK_ACK;
                                    nxt    <= sh[0] ? NX_TX : NX_PTR;
                                end else begin
                                    state  <= LK_IDLE;
                                end
                            end
                            LK_PTR: begin
                                ptr_q  <= sh[PTR_W-1:0];
                                pull_q <= 1'b1;
                                state  <= LK_ACK;
                                nxt    <= NX_WDATA;
                            end
                            default: begin
                                if (ptr_ok) begin
                                    pull_q <= 1'b1;
                                    state  <= LK_ACK;
                                    nxt    <= NX_IDLE;
                                end else begin
                                    state  <= LK_IDLE;
                                end
                            end
                        endcase
                    end
                end
                LK_ACK: begin
                    if (scl_fall) begin
                        case (nxt)
                            NX_PTR: begin
                                pull_q <= 1'b0;
                                state  <= LK_PTR;
                            end
                            NX_WDATA: begin
                                pull_q <= 1'b0;
                                state  <= LK_WDATA;
                            end
                            NX_TX: begin
                                sh     <= rd_data;
                                pull_q <= ~rd_data[BYTE_W-1];
                                cnt    <= '0;
                                state  <= LK_TX;
                            end
                            default: begin
                                pull_q <= 1'b0;
                                state  <= LK_IDLE;
                            end
                        endcase
                    end
                end
                LK_TX: begin
                    if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            pull_q <= 1'b0;
                            state  <= LK_IDLE;
                        end else begin
                            sh     <= {sh[BYTE_W-2:0], 1'b0};
                            pull_q <= ~sh[BYTE_W-2];
                            cnt    <= cnt + 4'd1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign wr_stb = (state == LK_WDATA) && scl_fall && (cnt == 4'd8) && ptr_ok
                    && !start_det && !stop_det;
    assign wr_data  = sh;
    assign ptr      = ptr_q;
    assign sda_pull = pull_q;
endmodule

// File: rtl/vreg_ctl_regs.sv
// Register file: control register with live status and the setpoint
// registers. Contents are cleared while the chip is disabled and reloaded
// with power-up values on the enable rising edge, which outranks a write.
// Assumes chip_en is synchronous to clk.
module vreg_ctl_regs
    import vreg_ctl_pkg::*;
#(
    parameter int                      PTR_W    = 3,
    parameter int                      N_SET    = 2,
    parameter logic [N_SET*BYTE_W-1:0] SET_DEFS = {8'h0A, 8'h1E}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    chip_en,
    input  logic                    wr_stb,
    input  logic [BYTE_W-1:0]       wr_data,
    input  logic [PTR_W-1:0]        ptr,
    input  logic [N_STAT-1:0]       stat,
    output logic [BYTE_W-1:0]       rd_data,
    output logic                    ptr_ok,
    output logic [1:0]              ctl_bits,
    output logic [N_SET*BYTE_W-1:0] set_val
);
    localparam logic [PTR_W-1:0] P_CTL = PTR_W'(CTL_IDX);
    localparam logic [PTR_W-1:0] P_END = PTR_W'(SET_BASE + N_SET);

    logic       chip_en_q;
    logic       en_rise;
    logic [1:0] ctl_q;

    // Remember the previous enable level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) chip_en_q <= 1'b0;
        else        chip_en_q <= chip_en;
    end

    assign en_rise = chip_en & ~chip_en_q;

    // Writable control bits: clear, reload, or take a write.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ctl_q <= '0;
        else if (!chip_en)              ctl_q <= '0;
        else if (en_rise)               ctl_q <= CTL_RESET_BITS;
        else if (wr_stb && ptr == P_CTL) ctl_q <= wr_data[1:0];
    end

    genvar i;
    generate
        for (i = 0; i < N_SET; i++) begin : g_set
            localparam logic [PTR_W-1:0] P_MINE = PTR_W'(SET_BASE + i);
            // One setpoint register with clear, reload and write.
            always_ff @(posedge clk) begin
                if (!rst_n)                       set_val[i*BYTE_W +: BYTE_W] <= '0;
                else if (!chip_en)                set_val[i*BYTE_W +: BYTE_W] <= '0;
                else if (en_rise)                 set_val[i*BYTE_W +: BYTE_W] <= SET_DEFS[i*BYTE_W +: BYTE_W];
                else if (wr_stb && ptr == P_MINE) set_val[i*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    endgenerate

    assign ptr_ok = (ptr >= P_CTL) && (ptr < P_END);

    // Read multiplexer; everything reads zero while disabled.
    always_comb begin
        rd_data = '0;
        if (chip_en) begin
            if (ptr == P_CTL) rd_data = {1'b0, stat, 2'b00, ctl_q};
            for (int k = 0; k < N_SET; k++) begin
                if (ptr == PTR_W'(SET_BASE + k)) rd_data = set_val[k*BYTE_W +: BYTE_W];
            end
        end
    end

    assign ctl_bits = ctl_q;
endmodule

// File: rtl/vreg_ctl_i2c.sv
// Top level of the regulator control register slave: synchroniser, bus
// state machine and register file. The SDA pad is open drain outside this
// block; sda_pull high means pull the line low.
module vreg_ctl_i2c
    import vreg_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h5B,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] SET0_DEF    = 8'h1E,
    parameter logic [7:0] SET1_DEF    = 8'h0A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       therm_trip,
    input  logic       undervolt,
    input  logic       power_ok,
    input  logic       chip_en,
    output logic       sda_pull,
    output logic       conv_on,
    output logic       slow_start,
    output logic [7:0] vset_lo,
    output logic [7:0] vset_hi
);
    localparam int PTR_W = 3;
    localparam int N_SET = 2;

    logic                    scl_lvl;
    logic                    sda_lvl;
    logic [N_STAT-1:0]       stat_q;
    logic                    scl_rise;
    logic                    scl_fall;
    logic                    start_det;
    logic                    stop_det;
    logic [BYTE_W-1:0]       rd_data;
    logic                    ptr_ok;
    logic                    wr_stb;
    logic [BYTE_W-1:0]       wr_data;
    logic [PTR_W-1:0]        ptr;
    logic [1:0]              ctl_bits;
    logic [N_SET*BYTE_W-1:0] set_val;

    vreg_ctl_sync #(.STAGES(SYNC_STAGES), .NS(N_STAT)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .stat_in   ({therm_trip, undervolt, power_ok}),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .stat_q    (stat_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    vreg_ctl_link #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_lvl   (sda_lvl),
        .rd_data   (rd_data),
        .ptr_ok    (ptr_ok),
        .sda_pull  (sda_pull),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .ptr       (ptr)
    );

    vreg_ctl_regs #(
        .PTR_W    (PTR_W),
        .N_SET    (N_SET),
        .SET_DEFS ({SET1_DEF, SET0_DEF})
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_en  (chip_en),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .ptr      (ptr),
        .stat     (stat_q),
        .rd_data  (rd_data),
        .ptr_ok   (ptr_ok),
        .ctl_bits (ctl_bits),
        .set_val  (set_val)
    );

    assign conv_on    = ctl_bits[0];
    assign slow_start = ctl_bits[1];
    assign vset_lo    = set_val[BYTE_W-1:0];
    assign vset_hi    = set_val[2*BYTE_W-1:BYTE_W];
endmodule

// File: rtl/vreg_ctl_chk.sv
// Property checker for vreg_ctl_i2c, attached by bind. It watches ports and
// the pulses passed between the synchroniser, the bus engine and the
// register file.
module vreg_ctl_chk #(
    parameter logic [7:0] SET0_DEF = 8'h1E,
    parameter logic [7:0] SET1_DEF = 8'h0A
) (
    input logic       clk,
    input logic       rst_n,
    input logic       chip_en,
    input logic       sda_pull,
    input logic       scl_lvl,
    input logic       start_det,
    input logic       stop_det,
    input logic       wr_stb,
    input logic       conv_on,
    input logic       slow_start,
    input logic [7:0] vset_lo,
    input logic [7:0] vset_hi
);
    // R7
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en && $past(!chip_en)) |->
        (vset_lo == 8'h00 && vset_hi == 8'h00 && !conv_on && !slow_start));

    // R6
    default_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_en) |=>
        (vset_lo == SET0_DEF && vset_hi == SET1_DEF && conv_on && !slow_start));

    // R12
    pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_lvl));

    // R9
    bus_cond_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !sda_pull);

    // R3
    setpoint_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(chip_en) && $past(chip_en, 2) && !$past(wr_stb))
        |-> ($stable(vset_lo) && $stable(vset_hi)));
endmodule

bind vreg_ctl_i2c vreg_ctl_chk #(.SET0_DEF(SET0_DEF), .SET1_DEF(SET1_DEF)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_en    (chip_en),
    .sda_pull   (sda_pull),
    .scl_lvl    (scl_lvl),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .wr_stb     (wr_stb),
    .conv_on    (conv_on),
    .slow_start (slow_start),
    .vset_lo    (vset_lo),
    .vset_hi    (vset_hi)
);

// File: tb/test_vreg_ctl_i2c.sv
module test_vreg_ctl_i2c;
    localparam int HALF = 10;
    localparam int Q    = HALF / 2;

    typedef struct packed {
        logic       is_rd;
        logic [7:0] ptr;
        logic [7:0] data;
        logic [7:0] exp;   // write: expected data ack (1/0); read: value
    } vec_t;

    localparam int N_VEC = 15;
    localparam vec_t VECS [N_VEC] = '{
        '{1'b1, 8'h01, 8'h00, 8'h51},   // R5 R6 status 101 + run bit
        '{1'b1, 8'h02, 8'h00, 8'h1E},   // R6 R4
        '{1'b1, 8'h03, 8'h00, 8'h0A},   // R6 R4
        '{1'b0, 8'h02, 8'h6E, 8'h01},   // R3 write acked
        '{1'b1, 8'h02, 8'h00, 8'h6E},   // R3 R4 readback
        '{1'b0, 8'h0B, 8'hAA, 8'h01},   // R2 upper pointer bits ignored
        '{1'b1, 8'h03, 8'h00, 8'hAA},   // R2
        '{1'b0, 8'h01, 8'hFF, 8'h01},   // R5 write all ones
        '{1'b1, 8'h01, 8'h00, 8'h53},   // R5 only bits 1:0 taken
        '{1'b0, 8'h00, 8'h55, 8'h00},   // R8 pointer 0 nack
        '{1'b0, 8'h05, 8'h55, 8'h00},   // R8 pointer 5 nack
        '{1'b1, 8'h00, 8'h00, 8'h00},   // R8 read pointer 0
        '{1'b1, 8'h07, 8'h00, 8'h00},   // R8 read pointer 7
        '{1'b1, 8'h02, 8'h00, 8'h6E},   // R8 nothing changed
        '{1'b0, 8'h01, 8'h00, 8'h01}    // R5 clear control bits
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, scl, sda_m, therm, uv, pok, chip_en;
    logic       sda_pull, conv_on, slow_start, sda_line;
    logic [7:0] vset_lo, vset_hi;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    assign sda_line = sda_m & ~sda_pull;

    vreg_ctl_i2c i_vreg_ctl_i2c (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl),
        .sda_in     (sda_line),
        .therm_trip (therm),
        .undervolt  (uv),
        .power_ok   (pok),
        .chip_en    (chip_en),
        .sda_pull   (sda_pull),
        .conv_on    (conv_on),
        .slow_start (slow_start),
        .vset_lo    (vset_lo),
        .vset_hi    (vset_hi)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        cyc(Q);
        if (!scl) begin
            sda_m = 1'b1; cyc(Q);
            scl = 1'b1;   cyc(HALF);
        end
        sda_m = 1'b0; cyc(HALF);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        cyc(Q); sda_m = 1'b0; cyc(Q);
        scl = 1'b1; cyc(HALF);
        sda_m = 1'b1; cyc(HALF);
    endtask

    task automatic put_bit(logic b);
        cyc(Q); sda_m = b; cyc(Q);
        scl = 1'b1; cyc(HALF);
        scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        cyc(Q); sda_m = 1'b1; cyc(Q);
        scl = 1'b1; cyc(Q);
        b = sda_line; cyc(HALF - Q);
        scl = 1'b0;
    endtask

    task automatic put_byte(logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        ack = !a;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(nack);
    endtask

    task automatic wr_reg(logic [7:0] p, logic [7:0] d, output logic a_ack, output logic d_ack);
        logic pa;
        bus_start();
        put_byte(8'hB6, a_ack);
        put_byte(p, pa);
        put_byte(d, d_ack);
        bus_stop();
    endtask

    task automatic rd_reg(logic [7:0] p, output logic [7:0] v);
        logic a;
        bus_start();
        put_byte(8'hB6, a);
        put_byte(p, a);
        bus_start();
        put_byte(8'hB7, a);
        get_byte(v, 1'b1);
        bus_stop();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    // Commit-versus-enable race: enable rises DLY negedges after the 8th SCL fall.
    task automatic race_write(int dly, logic [7:0] d);
        logic a;
        chip_en = 1'b0; cyc(4);
        bus_start();
        put_byte(8'hB6, a);
        put_byte(8'h02, a);
        for (int i = 7; i >= 1; i--) put_bit(d[i]);
        cyc(Q); sda_m = d[0]; cyc(Q);
        scl = 1'b1; cyc(HALF);
        scl = 1'b0;
        cyc(dly);
        chip_en = 1'b1;
        get_bit(a);
        bus_stop();
        cyc(4);
    endtask

    initial begin
        logic       aa, da, b, quiet;
        logic [7:0] v;
        rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; chip_en = 1'b0;
        therm = 1'b1; uv = 1'b0; pok = 1'b1;
        cyc(5);
        check("R7 reset vset_lo", vset_lo, 8'h00);
        check("R7 reset ctl/pull", {5'b0, conv_on, slow_start, sda_pull}, 8'h00);
        rst_n = 1'b1; cyc(5);
        check("R7 disabled vset_hi", vset_hi, 8'h00);

        // R7: writes and reads while disabled.
        wr_reg(8'h02, 8'h33, aa, da);
        rd_reg(8'h02, v);
        check("R7 disabled read reg2", v, 8'h00);
        rd_reg(8'h01, v);
        check("R7 disabled read reg1", v, 8'h00);

        chip_en = 1'b1; cyc(3);
        check("R6 vset_lo default", vset_lo, 8'h1E);
        check("R6 vset_hi default", vset_hi, 8'h0A);
        check("R6 control default", {6'b0, slow_start, conv_on}, 8'h01);

        // Vector table walk.
        for (int n = 0; n < N_VEC; n++) begin
            if (VECS[n].is_rd) begin
                rd_reg(VECS[n].ptr, v);
                check($sformatf("vector %0d read", n), v, VECS[n].exp);
            end else begin
                wr_reg(VECS[n].ptr, VECS[n].data, aa, da);
                check($sformatf("vector %0d write ack", n), {7'b0, da}, VECS[n].exp);
            end
        end
        check("R3 vset_lo port", vset_lo, 8'h6E);
        check("R3 vset_hi port", vset_hi, 8'hAA);
        check("R5 control ports", {6'b0, slow_start, conv_on}, 8'h00);

        // R1: foreign address is not acknowledged and writes nothing.
        wr_reg(8'h02, 8'h11, aa, da);
        check("R1 own address ack", {7'b0, aa}, 8'h01);
        bus_start();
        put_byte(8'hB4, aa);
        put_byte(8'h02, da);
        put_byte(8'h22, da);
        bus_stop();
        check("R1 foreign address nack", {7'b0, aa}, 8'h00);
        check("R1 foreign write ignored", vset_lo, 8'h11);

        // R9: STOP in the middle of a data byte.
        bus_start();
        put_byte(8'hB6, aa);
        put_byte(8'h02, aa);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_stop();
        cyc(4);
        check("R9 aborted write", vset_lo, 8'h11);
        check("R9 released", {7'b0, sda_pull}, 8'h00);
        // R9: START in the middle of the address byte restarts decoding.
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        put_byte(8'hB6, aa);
        put_byte(8'h03, aa);
        put_byte(8'h3C, da);
        bus_stop();
        check("R9 restart write", vset_hi, 8'h3C);

        // R10: after a read byte the slave stays off the line.
        bus_start();
        put_byte(8'hB6, aa);
        put_byte(8'h03, aa);
        bus_start();
        put_byte(8'hB7, aa);
        get_byte(v, 1'b1);
        check("R4 read 0x3C", v, 8'h3C);
        quiet = 1'b1;
        for (int i = 0; i < 9; i++) begin
            get_bit(b);
            quiet = quiet & b;
        end
        bus_stop();
        check("R10 released after read", {7'b0, quiet}, 8'h01);

        // R5: status bits track inputs live.
        therm = 1'b1; uv = 1'b1; pok = 1'b0; cyc(10);
        rd_reg(8'h01, v);
        check("R5 live status", v, 8'h60);

        // R11: enable edge and commit in one cycle, then one cycle apart.
        race_write(2, 8'h77);
        check("R11 same-cycle default wins", vset_lo, 8'h1E);
        race_write(1, 8'h77);
        check("R11 earlier edge lets write in", vset_lo, 8'h77);

        // R7: disabling clears the outputs.
        chip_en = 1'b0; cyc(3);
        check("R7 disable clears vset_lo", vset_lo, 8'h00);
        check("R7 disable clears run bit", {7'b0, conv_on}, 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule